// File: doc/BRIEF.md
# Three-Leg Half-Bridge Gate Controller

This block drives the gate enables of the three legs of a motor inverter. Each leg takes an active-high command for its upper switch and one for its lower switch. The block turns these into a pair of gate enables. It refuses to turn on both switches of a leg, and it keeps a leg fully off for a programmable gap before either switch turns on. One active-low shutdown level, one overcurrent trip flag and one supply undervoltage flag are shared by all legs. The undervoltage flag has an enable input. Every input is an asynchronous digital level and passes through a two-flop synchronizer.

An overcurrent trip disables every gate as soon as the synchronized flag is seen. It does not wait for the shared shutdown pin to fall. At the same moment the block pulls the shared pin down through an open-drain enable, and it keeps pulling until it reads the pin back as low. After that release the legs stay off for as long as the pin stays low, so the external network on the pin sets the restart time. A sticky status bit records that a trip happened and holds until a clear input is raised.

Top module: `leg_gate_ctrl`

## Requirements
- R1: While `rst_n` is low, every bit of `gate_hi` and `gate_lo` is 0, and `od_pull` and `flt_sticky` are 0.
- R2: With no shutdown, trip or enabled undervoltage, and after enough time to settle, leg i (bit i; 0 = U, 1 = V, 2 = W) behaves as follows. With only `cmd_hi[i]` high, `gate_hi[i]` = 1 and `gate_lo[i]` = 0. With only `cmd_lo[i]` high, `gate_lo[i]` = 1 and `gate_hi[i]` = 0. With both commands high or both low, both gates are 0.
- R3: `gate_hi[i]` and `gate_lo[i]` are never 1 in the same clock cycle, for any leg.
- R4: A gate enable rises only after its leg has had both gates at 0. When a leg is switched from one side to the other, the number of cycles with both gates at 0 is exactly DEAD.
- R5: A turn-on request whose synchronized command lasts DEAD cycles or fewer, counted from the cycle after the opposite gate drops, is cancelled and never reaches the gate. A request lasting DEAD+1 cycles turns the gate on.
- R6: While the synchronized `sd_in_n` is 0, all gates are 0, whatever the commands are.
- R7: A trip on `oc_trip` forces all gates to 0 and raises `od_pull` on the second clock edge after the input rises. This does not depend on `sd_in_n`.
- R8: After a trip, `od_pull` stays 1 until the synchronized `sd_in_n` reads 0. It drops on the next edge after that. The gates stay 0 until `sd_in_n` reads 1 again, and then they resume on the following edge.
- R9: When `uv_low` and `uv_lock_en` are both 1, all gates are 0. When `uv_low` is 1 and `uv_lock_en` is 0, the gates follow R2.
- R10: `flt_sticky` rises on the edge after the synchronized trip and clears on the edge after the synchronized `flt_clr` is seen. If a trip and a clear are present together, the trip wins.
- R11: From a leg that has been idle for at least DEAD cycles, a command change reaches the gate on the third clock edge: two synchronizer edges and one output register edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_hi | input | NLEG | Upper-switch commands, one bit per leg |
| cmd_lo | input | NLEG | Lower-switch commands, one bit per leg |
| sd_in_n | input | 1 | Sensed level of the shared shutdown pin, active low |
| oc_trip | input | 1 | Overcurrent comparator flag |
| uv_low | input | 1 | Supply undervoltage flag |
| uv_lock_en | input | 1 | Lets `uv_low` disable the gates |
| flt_clr | input | 1 | Clears the sticky trip status |
| gate_hi | output | NLEG | Upper-switch gate enables |
| gate_lo | output | NLEG | Lower-switch gate enables |
| od_pull | output | 1 | Open-drain pull-down enable for the shutdown pin |
| flt_sticky | output | 1 | Sticky record of a trip |

## Verification
The bench builds the block with NLEG = 3 and DEAD = 4. With these values all 64 combinations of the six command bits can be swept, each against all eight combinations of shutdown, undervoltage and undervoltage enable. The short gap also puts the exact dead-time count and the DEAD/DEAD+1 cancellation boundary within a few cycles. The trip sequence is followed edge by edge from the trip, through the pin read-back release, to the restart.

// File: rtl/leg_gate_pkg.sv
`timescale 1ns/1ps
package leg_gate_pkg;

  typedef struct packed {
    logic hi;
    logic lo;
  } leg_req_t;

  // Width of the gap counter for a gap of d cycles (at least one bit).
  function automatic int unsigned gap_width(input int unsigned d);
    return (d <= 1) ? 1 : $clog2(d);
  endfunction

  // Truth table of one leg: a single active command is passed on,
  // both or none give no request, and kill removes everything.
  function automatic leg_req_t leg_decode(input logic hi, input logic lo,
                                          input logic kill);
    leg_req_t r;
    r.hi = hi & ~lo & ~kill;
    r.lo = lo & ~hi & ~kill;
    return r;
  endfunction

endpackage

// File: rtl/leg_gate_sync.sv
`timescale 1ns/1ps
module leg_gate_sync #(
  parameter int unsigned W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_async,
  output logic [W-1:0] q_sync
);

  logic [W-1:0] meta_q;
  logic [W-1:0] stab_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      stab_q <= '0;
    end else begin
      meta_q <= d_async;
      stab_q <= meta_q;
    end
  end

  assign q_sync = stab_q;

endmodule

// File: rtl/leg_gate_fault.sv
`timescale 1ns/1ps
module leg_gate_fault (
  input  logic clk,
  input  logic rst_n,
  input  logic oc_s,
  input  logic sd_s,
  input  logic uv_s,
  input  logic uv_en_s,
  input  logic clr_s,
  output logic kill,
  output logic od_pull,
  output logic flt_sticky
);

  logic od_latch_q;
  logic sticky_q;
  logic uv_block;
  logic pin_low;

  assign pin_low  = ~sd_s;
  assign uv_block = uv_s & uv_en_s;

  // The latch stays set while the pin still reads high. A live trip re-arms it.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      od_latch_q <= 1'b0;
      sticky_q   <= 1'b0;
    end else begin
      od_latch_q <= oc_s | (od_latch_q & sd_s);
      sticky_q   <= oc_s | (sticky_q & ~clr_s);
    end
  end

  // The trip reaches kill directly, without passing through the pin.
  assign kill       = pin_low | oc_s | od_latch_q | uv_block;
  assign od_pull    = oc_s | od_latch_q;
  assign flt_sticky = sticky_q;

endmodule

// File: rtl/leg_gate_leg.sv
`timescale 1ns/1ps
module leg_gate_leg
  import leg_gate_pkg::*;
#(
  parameter int unsigned DEAD = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cmd_hi_s,
  input  logic cmd_lo_s,
  input  logic kill,
  output logic gate_hi,
  output logic gate_lo
);

  localparam int unsigned CW = gap_width(DEAD);
  localparam logic [CW-1:0] GAP_LAST = CW'(DEAD - 1);

  leg_req_t    req;
  logic        hi_q;
  logic        lo_q;
  logic [CW-1:0] gap_q;
  logic        gap_done;
  logic        leg_off;

  assign req      = leg_decode(cmd_hi_s, cmd_lo_s, kill);
  assign leg_off  = ~hi_q & ~lo_q;
  assign gap_done = (gap_q == GAP_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q  <= 1'b0;
      lo_q  <= 1'b0;
      gap_q <= '0;
    end else begin
      hi_q <= req.hi & (hi_q | (~lo_q & gap_done));
      lo_q <= req.lo & (lo_q | (~hi_q & gap_done));
      if (!leg_off)
        gap_q <= '0;
      else if (!gap_done)
        gap_q <= gap_q + 1'b1;
    end
  end

  // kill also masks the registered state, so gates drop in the cycle it appears.
  assign gate_hi = hi_q & ~kill;
  assign gate_lo = lo_q & ~kill;

endmodule

// File: rtl/leg_gate_ctrl.sv
`timescale 1ns/1ps
module leg_gate_ctrl #(
  parameter int unsigned NLEG = 3,
  parameter int unsigned DEAD = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NLEG-1:0] cmd_hi,
  input  logic [NLEG-1:0] cmd_lo,
  input  logic            sd_in_n,
  input  logic            oc_trip,
  input  logic            uv_low,
  input  logic            uv_lock_en,
  input  logic            flt_clr,
  output logic [NLEG-1:0] gate_hi,
  output logic [NLEG-1:0] gate_lo,
  output logic            od_pull,
  output logic            flt_sticky
);

  localparam int unsigned CMDW = 2 * NLEG;
  localparam int unsigned CTLW = 5;

  logic [CMDW-1:0] cmd_s;
  logic [CTLW-1:0] ctl_s;
  logic            sd_s;
  logic            oc_s;
  logic            uv_s;
  logic            uv_en_s;
  logic            clr_s;
  logic            kill;

  leg_gate_sync #(.W(CMDW)) u_cmd_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .d_async ({cmd_lo, cmd_hi}),
    .q_sync  (cmd_s)
  );

  leg_gate_sync #(.W(CTLW)) u_ctl_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .d_async ({flt_clr, uv_lock_en, uv_low, oc_trip, sd_in_n}),
    .q_sync  (ctl_s)
  );

  assign sd_s    = ctl_s[0];
  assign oc_s    = ctl_s[1];
  assign uv_s    = ctl_s[2];
  assign uv_en_s = ctl_s[3];
  assign clr_s   = ctl_s[4];

  leg_gate_fault u_fault (
    .clk        (clk),
    .rst_n      (rst_n),
    .oc_s       (oc_s),
    .sd_s       (sd_s),
    .uv_s       (uv_s),
    .uv_en_s    (uv_en_s),
    .clr_s      (clr_s),
    .kill       (kill),
    .od_pull    (od_pull),
    .flt_sticky (flt_sticky)
  );

  for (genvar g = 0; g < NLEG; g++) begin : g_leg
    leg_gate_leg #(.DEAD(DEAD)) u_leg (
      .clk      (clk),
      .rst_n    (rst_n),
      .cmd_hi_s (cmd_s[g]),
      .cmd_lo_s (cmd_s[NLEG + g]),
      .kill     (kill),
      .gate_hi  (gate_hi[g]),
      .gate_lo  (gate_lo[g])
    );
  end

endmodule

// File: rtl/leg_gate_chk.sv
`timescale 1ns/1ps
module leg_gate_chk #(
  parameter int unsigned NLEG = 3
) (
  input logic            clk,
  input logic            rst_n,
  input logic [NLEG-1:0] gate_hi,
  input logic [NLEG-1:0] gate_lo,
  input logic            od_pull,
  input logic            flt_sticky,
  input logic            oc_s,
  input logic            sd_s
);

  assert_no_overlap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_hi & gate_lo) == '0);

  assert_rise_after_gap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ((gate_lo & ~$past(gate_lo) & $past(gate_hi)) == '0) &&
    ((gate_hi & ~$past(gate_hi) & $past(gate_lo)) == '0));

  assert_pin_low_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !sd_s |-> (gate_hi == '0 && gate_lo == '0));

  assert_trip_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
    oc_s |-> (gate_hi == '0 && gate_lo == '0 && od_pull));

  assert_od_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (od_pull && sd_s) |=> od_pull);

  assert_sticky_set_R10: assert property (@(posedge clk) disable iff (!rst_n)
    oc_s |=> flt_sticky);

endmodule

bind leg_gate_ctrl leg_gate_chk #(.NLEG(NLEG)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .gate_hi    (gate_hi),
  .gate_lo    (gate_lo),
  .od_pull    (od_pull),
  .flt_sticky (flt_sticky),
  .oc_s       (oc_s),
  .sd_s       (sd_s)
);

// File: tb/leg_gate_ctrl_bench.sv
`timescale 1ns/1ps
module leg_gate_ctrl_bench;

  localparam int unsigned NLEG = 3;
  localparam int unsigned DEAD = 4;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [NLEG-1:0] cmd_hi = '0;
  logic [NLEG-1:0] cmd_lo = '0;
  logic            sd_in_n = 1'b1;
  logic            oc_trip = 1'b0;
  logic            uv_low = 1'b0;
  logic            uv_lock_en = 1'b0;
  logic            flt_clr = 1'b0;
  logic [NLEG-1:0] gate_hi;
  logic [NLEG-1:0] gate_lo;
  logic            od_pull;
  logic            flt_sticky;

  int n_chk = 0;
  int n_fail = 0;
  int overlap_cycles = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  leg_gate_ctrl #(.NLEG(NLEG), .DEAD(DEAD)) u_leg_gate_ctrl (
    .clk, .rst_n, .cmd_hi, .cmd_lo, .sd_in_n, .oc_trip, .uv_low,
    .uv_lock_en, .flt_clr, .gate_hi, .gate_lo, .od_pull, .flt_sticky
  );

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  always @(negedge clk)
    if (rst_n && ((gate_hi & gate_lo) != '0)) overlap_cycles++;

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int n;
    bit seen;
    // R1: reset holds everything off even with live inputs
    cmd_hi = 3'b001;
    oc_trip = 1'b1;
    tick(4);
    check("R1 gate_hi", 32'(gate_hi), 0);
    check("R1 gate_lo", 32'(gate_lo), 0);
    check("R1 od_pull", 32'(od_pull), 0);
    check("R1 sticky", 32'(flt_sticky), 0);
    oc_trip = 1'b0;
    cmd_hi = '0;
    tick(3);
    rst_n = 1'b1;
    tick(12);

    // R2, R6, R9: exhaustive command x gating sweep
    for (int c = 0; c < 64; c++) begin
      for (int m = 0; m < 8; m++) begin
        logic [2:0] h, l, eh, el;
        logic kl;
        h = c[2:0];
        l = c[5:3];
        cmd_hi = h;
        cmd_lo = l;
        sd_in_n = ~m[0];
        uv_low = m[1];
        uv_lock_en = m[2];
        kl = m[0] | (m[1] & m[2]);
        eh = kl ? 3'b000 : (h & ~l);
        el = kl ? 3'b000 : (l & ~h);
        tick(12);
        if (m[0])
          check("R6 sweep", {gate_hi, gate_lo}, {eh, el});
        else if (m[1])
          check("R9 sweep", {gate_hi, gate_lo}, {eh, el});
        else
          check("R2 sweep", {gate_hi, gate_lo}, {eh, el});
      end
    end
    sd_in_n = 1'b1;
    uv_low = 1'b0;
    uv_lock_en = 1'b0;
    cmd_hi = '0;
    cmd_lo = '0;
    tick(12);

    // R11: latency from idle leg
    cmd_hi = 3'b001;
    tick(2);
    check("R11 before third edge", 32'(gate_hi[0]), 0);
    tick(1);
    check("R11 at third edge", 32'(gate_hi[0]), 1);
    tick(8);

    // R4: exact gap when switching hi -> lo
    cmd_hi = '0;
    cmd_lo = 3'b001;
    tick(2);
    check("R4 hi still on", 32'(gate_hi[0]), 1);
    tick(1);
    check("R4 hi off", 32'(gate_hi[0]), 0);
    n = 0;
    while (gate_lo[0] == 1'b0 && n < 50) begin
      n++;
      tick(1);
    end
    check("R4 gap cycles", 32'(n), 32'(DEAD));
    tick(8);

    // R5: request of DEAD cycles is cancelled
    cmd_lo = '0;
    cmd_hi = 3'b001;
    tick(DEAD);
    cmd_hi = '0;
    seen = 1'b0;
    for (int k = 0; k < 20; k++) begin
      if (gate_hi[0]) seen = 1'b1;
      tick(1);
    end
    check("R5 cancelled at DEAD", 32'(seen), 0);
    check("R5 lo dropped", 32'(gate_lo[0]), 0);
    cmd_lo = 3'b001;
    tick(12);
    cmd_lo = '0;
    cmd_hi = 3'b001;
    tick(DEAD + 1);
    cmd_hi = '0;
    seen = 1'b0;
    for (int k = 0; k < 20; k++) begin
      if (gate_hi[0]) seen = 1'b1;
      tick(1);
    end
    check("R5 passes at DEAD+1", 32'(seen), 1);

    // R7, R8, R10: trip sequence
    cmd_hi = 3'b001;
    cmd_lo = 3'b010;
    tick(12);
    check("R2 mixed legs", {gate_hi, gate_lo}, {3'b001, 3'b010});
    oc_trip = 1'b1;
    tick(1);
    check("R7 still on after first edge", 32'(gate_hi), 32'(3'b001));
    tick(1);
    check("R7 gates off", {gate_hi, gate_lo}, 0);
    check("R7 od_pull on", 32'(od_pull), 1);
    oc_trip = 1'b0;
    tick(6);
    check("R8 od held while pin high", 32'(od_pull), 1);
    check("R8 gates held off", {gate_hi, gate_lo}, 0);
    check("R10 sticky set", 32'(flt_sticky), 1);
    sd_in_n = 1'b0;
    tick(2);
    check("R8 od before readback edge", 32'(od_pull), 1);
    tick(1);
    check("R8 od released", 32'(od_pull), 0);
    tick(4);
    check("R8 off while pin low", {gate_hi, gate_lo}, 0);
    sd_in_n = 1'b1;
    tick(2);
    check("R8 off until edge", {gate_hi, gate_lo}, 0);
    tick(1);
    check("R8 resumed", {gate_hi, gate_lo}, {3'b001, 3'b010});

    // R10: clear, then trip wins over clear
    flt_clr = 1'b1;
    tick(1);
    flt_clr = 1'b0;
    tick(1);
    check("R10 sticky before clear edge", 32'(flt_sticky), 1);
    tick(1);
    check("R10 sticky cleared", 32'(flt_sticky), 0);
    oc_trip = 1'b1;
    flt_clr = 1'b1;
    tick(5);
    check("R10 trip wins", 32'(flt_sticky), 1);
    oc_trip = 1'b0;
    flt_clr = 1'b0;
    tick(3);
    check("R10 stays set", 32'(flt_sticky), 1);

    check("R3 overlap cycles", 32'(overlap_cycles), 0);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule